// File: doc/BRIEF.md
# Low-Frequency Clock Quality Monitor

This block judges the health of a nominal 32 kHz clock by timing it with a fast reference clock (48 MHz in the target system). It passes the slow clock through a two-flop synchroniser and detects its rising edges. For every full input cycle it records the period and the high time, counted in reference cycles. It compares the period against a programmable window. It computes the duty variation as the distance of the high time from half the period, and compares that against a programmable ceiling. A run counter of consecutive good cycles declares the clock valid once it reaches a programmable threshold.

Each event sets a sticky bit in a seven-bit status vector. Software clears those bits by writing ones. The interrupt line is raised by any status bit whose enable is set. The period check, the duty check and the run counter each have their own enable. A counter-clear input restarts the measurement without touching the status vector.

Top module: `lfclk_monitor`

## Requirements
- R1: After reset, per_cnt, hi_cnt, duty_var, valid_cnt, irq_sts and irq are all zero.
- R2: per_cnt holds the number of reference cycles between the last two synchronised rising edges, and hi_cnt holds how many of those cycles the input was high. The first rising edge after reset, after a stall or after a counter clear only arms the measurement and captures nothing.
- R3: Every capture sets irq_sts[0]. When chk_en[0] is 1 and per_min <= period <= per_max, the capture sets irq_sts[1].
- R4: duty_var = |high - floor(period/2)|, updated on every capture. When chk_en[1] is 1 and duty_var <= duty_max, the capture sets irq_sts[2]. A capture that fails any enabled check sets irq_sts[3].
- R5: A check whose enable bit is 0 neither sets its pass bit nor causes a fail, so a period outside the window with chk_en[0]=0 still counts as good.
- R6: With chk_en[2]=1, valid_cnt increments (saturating) on each good capture and returns to 0 on a failed capture or a stall. When valid_cnt becomes equal to a nonzero valid_min, irq_sts[5] is set. With chk_en[2]=0, valid_cnt stays 0 and bit 5 is never set.
- R7: If 0xFFFF reference cycles pass without a rising edge, irq_sts[4] is set once for that gap, and the next edge only re-arms.
- R8: A failed capture or a stall that comes after validity was reached (and before any later failure or clear) sets irq_sts[6].
- R9: Writing 1 to sts_clr[i] clears irq_sts[i]. A set in the same cycle wins. A status bit is never cleared any other way.
- R10: irq is 1 exactly when (irq_sts & irq_en) is nonzero.
- R11: While count_clr is 1, per_cnt, hi_cnt, duty_var and valid_cnt are zero and the measurement is disarmed. irq_sts is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk_in | input | 1 | Slow clock under test, asynchronous |
| count_clr | input | 1 | Clears counters and measurement state |
| chk_en | input | 3 | Check enables: bit0 period, bit1 duty, bit2 run count |
| per_min | input | 16 | Lowest acceptable period |
| per_max | input | 16 | Highest acceptable period |
| duty_max | input | 16 | Largest acceptable duty variation |
| valid_min | input | 8 | Good-cycle run needed for validity |
| irq_en | input | 7 | Interrupt enable per status bit |
| sts_clr | input | 7 | Write-one-to-clear strobes for status |
| per_cnt | output | 16 | Last captured period |
| hi_cnt | output | 16 | Last captured high time |
| duty_var | output | 16 | Last duty variation |
| valid_cnt | output | 8 | Current good-cycle run |
| irq_sts | output | 7 | Sticky status: 0 ready, 1 period ok, 2 duty ok, 3 fail, 4 stall, 5 valid, 6 unwell |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the limits and enables stay stable while slow-clock edges are being judged. For example, the check that validity rises with the run count equal to valid_min only holds if valid_min does not move in that cycle. The stimulus changes configuration only while count_clr is held and the input is low. The slow clock is driven on the falling edge of the reference clock, so the synchroniser sees clean levels and the measured period and high time equal the driven counts exactly.

// File: rtl/lfmon_pkg.sv
package lfmon_pkg;
    localparam int STS_W      = 7;
    localparam int ST_READY   = 0;
    localparam int ST_PER_OK  = 1;
    localparam int ST_DUTY_OK = 2;
    localparam int ST_FAIL    = 3;
    localparam int ST_STALL   = 4;
    localparam int ST_VALID   = 5;
    localparam int ST_UNWELL  = 6;
    localparam int EN_W       = 3;
    localparam int EN_PER     = 0;
    localparam int EN_DUTY    = 1;
    localparam int EN_RUN     = 2;
    typedef logic [STS_W-1:0] sts_vec_t;
endpackage

// File: rtl/lfmon_sync_edge.sv
module lfmon_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.chain[STAGES-1];
    assign rise = lvl & ~s_q.prev;

    // R2
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/lfmon_meas.sv
module lfmon_meas #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lvl,
    input  logic             rise,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] hi_o,
    output logic             cap_vld,
    output logic             stall_pls
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] per_cap;
        logic [CNT_W-1:0] hi_cap;
        logic             armed;
        logic             stalled;
        logic             vld;
        logic             stall;
    } st_t;

    st_t m_d, m_q;

    always_comb begin
        m_d       = m_q;
        m_d.vld   = 1'b0;
        m_d.stall = 1'b0;
        if (clr) begin
            m_d.run     = '0;
            m_d.hi      = '0;
            m_d.per_cap = '0;
            m_d.hi_cap  = '0;
            m_d.armed   = 1'b0;
            m_d.stalled = 1'b0;
        end else if (rise) begin
            if (m_q.armed) begin
                m_d.per_cap = m_q.run;
                m_d.hi_cap  = m_q.hi;
                m_d.vld     = 1'b1;
            end
            m_d.armed   = 1'b1;
            m_d.stalled = 1'b0;
            m_d.run     = ONE;
            m_d.hi      = ONE;
        end else begin
            if (m_q.run != CMAX) m_d.run = m_q.run + ONE;
            if (lvl && m_q.hi != CMAX) m_d.hi = m_q.hi + ONE;
            if (m_q.run == CMAX && !m_q.stalled) begin
                m_d.stall   = 1'b1;
                m_d.stalled = 1'b1;
                m_d.armed   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign per_o     = m_q.per_cap;
    assign hi_o      = m_q.hi_cap;
    assign cap_vld   = m_q.vld;
    assign stall_pls = m_q.stall;

    // R2
    high_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> (hi_o <= per_o));

    // R7
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pls |=> !stall_pls);
endmodule

// File: rtl/lfmon_judge.sv
module lfmon_judge
    import lfmon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [EN_W-1:0]  chk_en,
    input  logic [CNT_W-1:0] per_min,
    input  logic [CNT_W-1:0] per_max,
    input  logic [CNT_W-1:0] duty_max,
    input  logic [VAL_W-1:0] valid_min,
    input  sts_vec_t         sts_clr,
    input  logic             cap_vld,
    input  logic             stall_pls,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic [CNT_W-1:0] dv_o,
    output logic [VAL_W-1:0] cnt_o,
    output sts_vec_t         sts_o
);
    localparam logic [VAL_W-1:0] VMAX = '1;
    localparam logic [VAL_W-1:0] VONE = VAL_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] dv;
        logic [VAL_W-1:0] cnt;
        logic             reached;
        sts_vec_t         sts;
    } st_t;

    st_t j_d, j_q;

    logic [CNT_W-1:0] half, dv_now;
    logic             per_in, duty_in, bad;
    logic [VAL_W-1:0] cnt_inc;
    sts_vec_t         set_v;

    always_comb begin
        half    = per_i >> 1;
        dv_now  = (hi_i >= half) ? (hi_i - half) : (half - hi_i);
        per_in  = (per_i >= per_min) && (per_i <= per_max);
        duty_in = (dv_now <= duty_max);
        bad     = (chk_en[EN_PER] && !per_in) || (chk_en[EN_DUTY] && !duty_in);
        cnt_inc = (j_q.cnt == VMAX) ? j_q.cnt : j_q.cnt + VONE;
    end

    always_comb begin
        j_d   = j_q;
        set_v = '0;
        if (cap_vld) begin
            j_d.dv               = dv_now;
            set_v[ST_READY]   = 1'b1;
            set_v[ST_PER_OK]  = chk_en[EN_PER] && per_in;
            set_v[ST_DUTY_OK] = chk_en[EN_DUTY] && duty_in;
            set_v[ST_FAIL]    = bad;
            if (chk_en[EN_RUN]) begin
                if (bad) begin
                    j_d.cnt = '0;
                    if (j_q.reached) set_v[ST_UNWELL] = 1'b1;
                    j_d.reached = 1'b0;
                end else begin
                    j_d.cnt = cnt_inc;
                    if (cnt_inc == valid_min && j_q.cnt != valid_min && valid_min != '0) begin
                        set_v[ST_VALID] = 1'b1;
                        j_d.reached     = 1'b1;
                    end
                end
            end else begin
                j_d.cnt     = '0;
                j_d.reached = 1'b0;
            end
        end
        if (stall_pls) begin
            set_v[ST_STALL] = 1'b1;
            if (chk_en[EN_RUN]) begin
                j_d.cnt = '0;
                if (j_q.reached) set_v[ST_UNWELL] = 1'b1;
                j_d.reached = 1'b0;
            end
        end
        if (clr) begin
            j_d.dv      = '0;
            j_d.cnt     = '0;
            j_d.reached = 1'b0;
        end
        j_d.sts = (j_q.sts & ~sts_clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign dv_o  = j_q.dv;
    assign cnt_o = j_q.cnt;
    assign sts_o = j_q.sts;

    // R9
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(j_q.sts) & ~j_q.sts & ~$past(sts_clr)) == '0));

    // R4
    fail_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(j_q.sts[ST_FAIL]) |-> $past(cap_vld));

    // R6
    valid_at_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(j_q.sts[ST_VALID]) |-> (j_q.cnt == valid_min));

    // R7
    stall_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(j_q.sts[ST_STALL]) |-> $past(stall_pls));
endmodule

// File: rtl/lfclk_monitor.sv
module lfclk_monitor
    import lfmon_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int VAL_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_clk_in,
    input  logic             count_clr,
    input  logic [2:0]       chk_en,
    input  logic [CNT_W-1:0] per_min,
    input  logic [CNT_W-1:0] per_max,
    input  logic [CNT_W-1:0] duty_max,
    input  logic [VAL_W-1:0] valid_min,
    input  logic [6:0]       irq_en,
    input  logic [6:0]       sts_clr,
    output logic [CNT_W-1:0] per_cnt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] duty_var,
    output logic [VAL_W-1:0] valid_cnt,
    output logic [6:0]       irq_sts,
    output logic             irq
);
    logic lf_lvl, lf_rise, cap_vld, stall_pls;
    logic [CNT_W-1:0] per_w, hi_w;

    lfmon_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(lf_clk_in),
        .lvl(lf_lvl), .rise(lf_rise)
    );

    lfmon_meas #(.CNT_W(CNT_W)) u_meas (
        .clk(clk), .rst_n(rst_n), .clr(count_clr),
        .lvl(lf_lvl), .rise(lf_rise),
        .per_o(per_w), .hi_o(hi_w),
        .cap_vld(cap_vld), .stall_pls(stall_pls)
    );

    lfmon_judge #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .clr(count_clr),
        .chk_en(chk_en), .per_min(per_min), .per_max(per_max),
        .duty_max(duty_max), .valid_min(valid_min), .sts_clr(sts_clr),
        .cap_vld(cap_vld), .stall_pls(stall_pls),
        .per_i(per_w), .hi_i(hi_w),
        .dv_o(duty_var), .cnt_o(valid_cnt), .sts_o(irq_sts)
    );

    assign per_cnt = per_w;
    assign hi_cnt  = hi_w;
    assign irq     = |(irq_sts & irq_en);

    // R11
    clear_zeroes_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(count_clr) |-> (valid_cnt == '0 && per_cnt == '0));
endmodule

// File: tb/sim_lfclk_monitor.sv
module sim_lfclk_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lf = 1'b0;
    logic clr = 1'b0;
    logic [2:0] chk_en = 3'b111;
    logic [15:0] per_min = 16'd40, per_max = 16'd60, duty_max = 16'd4;
    logic [7:0] valid_min = 8'd3;
    logic [6:0] irq_en = '0, sts_clr = '0;
    logic [15:0] per_cnt, hi_cnt, duty_var;
    logic [7:0] valid_cnt;
    logic [6:0] irq_sts;
    logic irq;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    lfclk_monitor u0 (
        .clk(clk), .rst_n(rst_n), .lf_clk_in(lf), .count_clr(clr),
        .chk_en(chk_en), .per_min(per_min), .per_max(per_max),
        .duty_max(duty_max), .valid_min(valid_min), .irq_en(irq_en),
        .sts_clr(sts_clr), .per_cnt(per_cnt), .hi_cnt(hi_cnt),
        .duty_var(duty_var), .valid_cnt(valid_cnt), .irq_sts(irq_sts), .irq(irq)
    );

    // {period, high, cycles}
    localparam logic [47:0] VEC [11] = '{
        {16'd50, 16'd25, 16'd4}, {16'd40, 16'd20, 16'd4}, {16'd60, 16'd30, 16'd4},
        {16'd39, 16'd19, 16'd4}, {16'd61, 16'd30, 16'd4}, {16'd50, 16'd29, 16'd4},
        {16'd50, 16'd30, 16'd4}, {16'd51, 16'd21, 16'd4}, {16'd45, 16'd10, 16'd2},
        {16'd50, 16'd25, 16'd2}, {16'd50, 16'd25, 16'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk); lf = 1'b0; clr = 1'b1; sts_clr = 7'h7f;
        @(negedge clk); sts_clr = '0;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic lf_cycle(input int p, input int h);
        lf = 1'b1; repeat (h) @(negedge clk);
        lf = 1'b0; repeat (p - h) @(negedge clk);
    endtask

    task automatic close_rise();
        lf = 1'b1; repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 per_cnt", per_cnt, 0); chk("R1 irq_sts", irq_sts, 0); chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid_cnt", valid_cnt, 0); chk("R1 duty_var", duty_var, 0);

        for (int i = 0; i < 11; i++) begin
            int p, h, n, hf, dv;
            logic pin, din, ok;
            logic [6:0] es;
            p = int'(VEC[i][47:32]); h = int'(VEC[i][31:16]); n = int'(VEC[i][15:0]);
            restart();
            for (int k = 0; k < n + 1; k++) lf_cycle(p, h);
            close_rise();
            hf = p / 2; dv = (h >= hf) ? h - hf : hf - h;
            pin = (p >= 40 && p <= 60); din = (dv <= 4); ok = pin && din;
            es = {1'b0, ok && n >= 3, 1'b0, !ok, din, pin, 1'b1};
            // the first of n+1 cycles only arms, so n+1 generated cycles give n+1 captures
            // after the closing rise minus the arming edge: n+1 captures total
            chk("R2 period", per_cnt, p);
            chk("R2 high", hi_cnt, h);
            chk("R4 duty_var", duty_var, dv);
            chk("R6 valid_cnt", valid_cnt, ok ? ((n + 1 >= 255) ? 255 : n + 1) : 0);
            es[5] = ok && (n + 1 >= 3);
            chk("R3 R4 status", irq_sts, es);
            if (rst_n == 1'b0) lf = 1'b0;
        end

        // last vector passed with valid: status 0x27
        irq_en = 7'h08; @(negedge clk); chk("R10 masked", irq, 0);
        irq_en = 7'h20; @(negedge clk); chk("R10 enabled", irq, 1);
        sts_clr = 7'h01; @(negedge clk); sts_clr = '0; @(negedge clk);
        chk("R9 w1c", irq_sts, 7'h26);
        irq_en = 7'h01; @(negedge clk); chk("R10 cleared bit", irq, 0);
        irq_en = '0;

        chk_en = 3'b110; restart();
        repeat (5) lf_cycle(39, 19); close_rise();
        chk("R5 period off status", irq_sts, 7'h25);
        chk("R5 period off run", valid_cnt, 5);

        chk_en = 3'b011; restart();
        repeat (5) lf_cycle(50, 25); close_rise();
        chk("R6 run off status", irq_sts, 7'h07);
        chk("R6 run off count", valid_cnt, 0);

        chk_en = 3'b111; restart();
        repeat (3) lf_cycle(50, 25); lf_cycle(30, 15); close_rise();
        chk("R8 unwell status", irq_sts, 7'h6f);
        chk("R8 run reset", valid_cnt, 0);

        @(negedge clk); lf = 1'b0; clr = 1'b1; repeat (2) @(negedge clk);
        chk("R11 period", per_cnt, 0); chk("R11 high", hi_cnt, 0);
        chk("R11 duty", duty_var, 0); chk("R11 status kept", irq_sts, 7'h6f);
        clr = 1'b0;

        restart();
        repeat (3) lf_cycle(50, 25); close_rise();
        chk("R6 reached", irq_sts, 7'h27);
        repeat (65600) @(negedge clk);
        chk("R7 stall status", irq_sts, 7'h77);
        chk("R7 run reset", valid_cnt, 0);
        chk("R7 period kept", per_cnt, 50);
        lf = 1'b0; repeat (4) @(negedge clk);
        lf_cycle(50, 25); close_rise();
        chk("R7 re-arm only", irq_sts, 7'h77);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule